// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which operating mode a network-timing digital PLL runs in. It has three modes. In holdover the loop runs from a stored frequency on the free local oscillator. In normal the loop tracks the selected reference. The third mode is a TIE-correction phase that leads into normal. The block watches the following inputs:
- a request for normal operation;
- a disruption flag for the selected reference;
- the 2-bit reference select;
- a change pulse from an automatic reference selector;
- a control bit that chooses how recovery handles phase;
- a completion signal from the TIE correction logic.

Recovery from holdover can take one of two paths. On the direct path the block pulses an alignment request, so the output phase snaps to the input. On the phase-preserving path the block pulses a start request to the TIE correction logic. It then waits in the TIE state until that logic reports completion. Any change of reference always forces the phase-preserving path, whatever the control bit says. That choice is held in a sticky flag until normal mode is reached.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: During and after reset the mode is holdover (`mode`=2'b00), `hold_en` is 1, and `align_pulse` and `tie_start` are 0.
- R2: While in holdover with the reference disrupted (`ref_bad`=1), the mode stays holdover.
- R3: From holdover, with the reference not disrupted, `hitless`=0 and no pending reference change, the mode becomes normal (2'b10) on the next clock edge. `align_pulse` is high for exactly that one cycle.
- R4: From holdover, with the reference not disrupted and `hitless`=1, the mode becomes TIE (2'b01) on the next edge. `tie_start` is high for exactly that one cycle.
- R5: The TIE mode moves to normal only on an edge where `tie_done`=1. If the reference is disrupted while in TIE, the mode returns to holdover instead. `ref_bad` takes priority over `tie_done`.
- R6: In normal mode, `ref_bad`=1 moves the mode to holdover on the next edge.
- R7: Two events count as a reference change: a change of `ref_sel` from its value on the previous clock, or `ref_swap`=1. From any mode, a reference change forces holdover on the next edge. The next recovery then goes through TIE regardless of `hitless`. This forced path stays pending until normal mode is reached. A `ref_sel` difference on the first clock after reset does not count as a change.
- R8: A `ref_sel` code of 2'b11 selects no reference and is treated as disrupted. Codes 0, 1 and 2 select one of three references.
- R9: With `norm_req`=0 the mode is holdover on the next edge, and stays there.
- R10: `hold_en` is 1 exactly when the mode is holdover. `align_pulse` and `tie_start` are never high together. Each of them is high only in the first cycle of the mode it leads into.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| norm_req | input | 1 | Request for normal operation |
| ref_bad | input | 1 | Selected reference is disrupted |
| ref_sel | input | 2 | Reference select (0..2; 3 = none) |
| ref_swap | input | 1 | Automatic selector changed reference (pulse) |
| hitless | input | 1 | 1 = recover through TIE correction, 0 = direct alignment |
| tie_done | input | 1 | TIE correction has completed |
| mode | output | 2 | 00 holdover, 01 TIE correction, 10 normal |
| align_pulse | output | 1 | One-cycle request to align output phase to input |
| tie_start | output | 1 | One-cycle request to begin TIE correction |
| hold_en | output | 1 | Holdover active |

## Verification
The bench targets the following corner cases:
- **Reference change in normal mode with `hitless`=0.** A design that forgets the forced path would pulse `align_pulse` and break the phase relation that a change of reference must keep.
- **Disruption during TIE.** Raising `ref_bad` at the same edge as `tie_done` catches a wrong priority, which would reach normal on a bad reference.
- **The first clock after reset.** This catches a false reference change seen on that clock.
- **Select code 3.** This catches a controller that locks to a nonexistent input.

Long random runs with a fixed seed compare every output against a bench model in every cycle. They expose pulses that last two cycles and a sticky flag that clears too early or never clears.

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       norm_req,
  input  logic       ref_bad,
  input  logic [1:0] ref_sel,
  input  logic       ref_swap,
  input  logic       hitless,
  input  logic       tie_done,
  output logic [1:0] mode,
  output logic       align_pulse,
  output logic       tie_start,
  output logic       hold_en
);
  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_TIE  = 2'b01;
  localparam logic [1:0] M_NORM = 2'b10;
  localparam logic [1:0] SEL_NONE = 2'b11;

  logic [1:0] state_q, state_d;
  logic [1:0] sel_q;
  logic       primed_q, force_q, force_d;
  logic       bad, changed;

  assign bad     = ref_bad || (ref_sel == SEL_NONE);
  assign changed = (primed_q && (ref_sel != sel_q)) || ref_swap;

  always_comb begin
    state_d = state_q;
    if (!norm_req || changed) begin
      state_d = M_HOLD;
    end else begin
      case (state_q)
        M_HOLD: if (!bad) state_d = (hitless || force_q) ? M_TIE : M_NORM;
        M_TIE:  if (bad) state_d = M_HOLD;
                else if (tie_done) state_d = M_NORM;
        M_NORM: if (bad) state_d = M_HOLD;
        default: state_d = M_HOLD;
      endcase
    end
  end

  assign force_d = changed ? 1'b1 : (state_d == M_NORM) ? 1'b0 : force_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= M_HOLD;
      sel_q       <= 2'b00;
      primed_q    <= 1'b0;
      force_q     <= 1'b0;
      align_pulse <= 1'b0;
      tie_start   <= 1'b0;
    end else begin
      state_q     <= state_d;
      sel_q       <= ref_sel;
      primed_q    <= 1'b1;
      force_q     <= force_d;
      align_pulse <= (state_q == M_HOLD) && (state_d == M_NORM);
      tie_start   <= (state_q == M_HOLD) && (state_d == M_TIE);
    end
  end

  assign mode    = state_q;
  assign hold_en = (state_q == M_HOLD);
endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       norm_req,
  input logic       ref_bad,
  input logic [1:0] ref_sel,
  input logic       ref_swap,
  input logic       hitless,
  input logic       tie_done,
  input logic [1:0] mode,
  input logic       align_pulse,
  input logic       tie_start,
  input logic       hold_en
);
  a_r2_stay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && ref_bad) |=> mode == 2'b00);
  a_r3_align_entry: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |-> (mode == 2'b10 && $past(mode) == 2'b00));
  a_r4_tie_entry: assert property (@(posedge clk) disable iff (!rst_n)
    tie_start |-> (mode == 2'b01 && $past(mode) == 2'b00));
  a_r5_tie_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && ref_bad) |=> mode == 2'b00);
  a_r6_norm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && ref_bad) |=> mode == 2'b00);
  a_r7_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ref_swap |=> mode == 2'b00);
  a_r9_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_req |=> hold_en);
  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(align_pulse && tie_start));
endmodule

bind dpll_mode_ctrl dpll_mode_chk u_chk (.*);

// File: tb/dpll_mode_ctrl_test.sv
`timescale 1ns/1ps
module dpll_mode_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic norm_req = 1'b1, ref_bad = 1'b1, ref_swap = 1'b0, hitless = 1'b0, tie_done = 1'b0;
  logic [1:0] ref_sel = 2'b00;
  logic [1:0] mode;
  logic align_pulse, tie_start, hold_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [1:0] m_st, m_prev;
  logic m_force, m_prim, m_align, m_tie;

  always #5 clk = ~clk;

  dpll_mode_ctrl uut (.clk, .rst_n, .norm_req, .ref_bad, .ref_sel, .ref_swap,
                      .hitless, .tie_done, .mode, .align_pulse, .tie_start, .hold_en);

  task automatic model_reset();
    m_st = 2'b00; m_prev = 2'b00; m_force = 1'b0; m_prim = 1'b0;
    m_align = 1'b0; m_tie = 1'b0;
  endtask

  function automatic logic [1:0] next_mode(logic [1:0] st, logic frc, logic chg);
    logic bad;
    bad = ref_bad || ref_sel == 2'b11;
    if (!norm_req || chg) return 2'b00;
    if (st == 2'b00) return bad ? 2'b00 : ((hitless || frc) ? 2'b01 : 2'b10);
    if (st == 2'b01) return bad ? 2'b00 : (tie_done ? 2'b10 : 2'b01);
    return bad ? 2'b00 : 2'b10;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (mode !== m_st || hold_en !== (m_st == 2'b00) ||
        align_pulse !== m_align || tie_start !== m_tie) begin
      errors++;
      $display("FAIL %s: mode=%b hold=%b align=%b tie=%b expected mode=%b hold=%b align=%b tie=%b",
               tag, mode, hold_en, align_pulse, tie_start,
               m_st, (m_st == 2'b00), m_align, m_tie);
    end
  endtask

  task automatic tick(string tag);
    logic chg;
    logic [1:0] nx;
    chg = (m_prim && ref_sel != m_prev) || ref_swap;
    nx = next_mode(m_st, m_force, chg);
    m_align = (m_st == 2'b00) && nx == 2'b10;
    m_tie   = (m_st == 2'b00) && nx == 2'b01;
    m_force = chg ? 1'b1 : (nx == 2'b10 ? 1'b0 : m_force);
    m_st = nx; m_prev = ref_sel; m_prim = 1'b1;
    @(negedge clk);
    compare(tag);
    ref_swap = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    model_reset();
    ref_sel = 2'b10;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    ref_sel = 2'b01;
    tick("R1 first clock, no false change");
    tick("R2 hold while disrupted");
    tick("R2 hold while disrupted");
    ref_bad = 1'b0; hitless = 1'b0;
    tick("R3 direct recovery with align");
    tick("R3 align single cycle");
    ref_bad = 1'b1;
    tick("R6 normal to holdover");
    ref_bad = 1'b0; hitless = 1'b1;
    tick("R4 TIE entry with start pulse");
    tick("R5 wait in TIE without done");
    ref_bad = 1'b1; tie_done = 1'b1;
    tick("R5 disrupted beats done in TIE");
    ref_bad = 1'b0; tie_done = 1'b0;
    tick("R4 TIE again");
    tie_done = 1'b1;
    tick("R5 done leads to normal");
    tie_done = 1'b0; hitless = 1'b0;
    ref_sel = 2'b10;
    tick("R7 select change forces holdover");
    tick("R7 recovery via TIE despite hitless=0");
    tie_done = 1'b1;
    tick("R7 normal after TIE");
    tie_done = 1'b0; ref_swap = 1'b1;
    tick("R7 auto swap forces holdover");
    tick("R7 swap recovery via TIE");
    tie_done = 1'b1;
    tick("R7 normal clears pending path");
    tie_done = 1'b0; ref_bad = 1'b1;
    tick("R6 drop");
    ref_bad = 1'b0;
    tick("R7 sticky cleared, direct align");
    ref_sel = 2'b11;
    tick("R8 change to code 3");
    tick("R8 code 3 treated as disrupted");
    ref_sel = 2'b00;
    tick("R7 leave code 3");
    norm_req = 1'b0;
    tick("R9 no request");
    tick("R9 stays holdover");
    norm_req = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      norm_req = ($urandom % 20) != 0;
      ref_bad  = ($urandom % 4) == 0;
      hitless  = $urandom % 2;
      tie_done = ($urandom % 3) == 0;
      ref_swap = ($urandom % 25) == 0;
      if (($urandom % 15) == 0) ref_sel = $urandom % 4;
      tick("R10 random sequence");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule